// File: doc/BRIEF.md
# Peripheral access guard

The guard sits between one bus master and up to 64 peripheral register windows. Every access is decoded to a peripheral number and to one of two address aliases, secure or non-secure. The access is then tested against a per-peripheral "privileged only" bit held in two 32-bit protection words, and against a fixed secure/non-secure attribute for each peripheral. An access that fails either test is stopped inside the same cycle. No peripheral select and no write strobe leave the guard, a read returns zero, and a write completes normally with nothing stored.

Each rejected access raises one of two pending flags, one for privilege faults and one for security faults. The first offending peripheral number is kept in a fault-identity register for as long as any flag stays pending. An interrupt line is raised by any pending flag whose enable bit is set. A small word-addressed configuration port gives access to the global check enable, the protection words, the flags (with write-one-to-set and write-one-to-clear words), the interrupt enables and the fault identity.

Top module: `periph_guard`

## Requirements
- R1: Bus address bit 15 selects the secure alias, bits 14:9 give the peripheral number, and bits 8:0 are forwarded on `p_addr_o`. An allowed access to peripheral n asserts only `p_sel_o[n]`, and `p_we_o` follows `m_we_i`.
- R2: Peripheral n (0..31) is protected by bit n of protection word low (config word 1). Peripheral 32+n is protected by bit n of protection word high (config word 2). An access with `m_priv_i`=0 to a protected peripheral drives no select and no write strobe in the same cycle, while a privileged access passes.
- R3: A blocked read returns all-zero on `m_rdata_o`. An allowed read returns `p_rdata_i`.
- R4: A privilege fault sets flag bit 0 (config word 3) at the next clock edge, and the fault identity register (config word 7) takes the peripheral number.
- R5: An access through the non-secure alias to a secure peripheral, through the secure alias to a non-secure peripheral, or through the secure alias with `m_sec_i`=0 is blocked and sets flag bit 1. The peripheral number is recorded as in R4.
- R6: While any flag stays pending and is not cleared, the fault identity holds its first value. If a hardware fault arrives in the same cycle as a clear of every pending flag, the new number is recorded and the hardware flag stays set.
- R7: `irq_o` is high when (flags AND interrupt enables, config word 6) is non-zero. Turning an enable on while its flag is already pending raises `irq_o`.
- R8: Writing config word 4 sets the flag bits written as 1. Writing config word 5 clears them.
- R9: Bit 0 of config word 0 is the global check enable. When it is 0, every access passes and no flag is raised. Reset values: enable 1, protection words 0, flags 0, interrupt enables 0, fault identity 0.
- R10: Writes to config words 0, 1 and 2 take effect only when `c_priv_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| m_req_i | input | 1 | master access valid |
| m_we_i | input | 1 | master write |
| m_addr_i | input | 16 | master byte address |
| m_wdata_i | input | 32 | master write data |
| m_priv_i | input | 1 | access is privileged |
| m_sec_i | input | 1 | access is secure |
| m_rdata_o | output | 32 | read data to master |
| p_sel_o | output | 64 | one-hot peripheral select |
| p_we_o | output | 1 | peripheral write strobe |
| p_addr_o | output | 9 | offset inside peripheral window |
| p_wdata_o | output | 32 | peripheral write data |
| p_rdata_i | input | 32 | peripheral read data |
| c_req_i | input | 1 | config access valid |
| c_we_i | input | 1 | config write |
| c_addr_i | input | 3 | config word index |
| c_wdata_i | input | 32 | config write data |
| c_priv_i | input | 1 | config access is privileged |
| c_rdata_o | output | 32 | config read data |
| irq_o | output | 1 | fault interrupt |

## Verification
Two functions can fall in the same clock edge: a hardware fault that sets a flag and a software write-one-to-clear of the pending flags. The bench leaves a privilege fault pending. It then drives, in one cycle, a secure-alias violation on the bus and a clear of both flags on the config port. It expects the privilege flag gone, the security flag set, and the fault identity replaced by the new peripheral number. A second case raises a new fault with no clear, and expects the old identity to hold.

// File: rtl/periph_guard_pkg.sv
package periph_guard_pkg;
  localparam int CFG_W   = 32;
  localparam int FLAG_W  = 2;
  localparam int FLG_PRIV = 0;
  localparam int FLG_SEC  = 1;
  localparam int MAX_PERIPH = 64;

  typedef enum logic [2:0] {
    REG_CTRL    = 3'd0,
    REG_PROT_LO = 3'd1,
    REG_PROT_HI = 3'd2,
    REG_FLAGS   = 3'd3,
    REG_SET     = 3'd4,
    REG_CLR     = 3'd5,
    REG_IEN     = 3'd6,
    REG_FID     = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/pg_decode.sv
module pg_decode #(
  parameter int NP    = 64,
  parameter int OFS_W = 9,
  parameter int IDW   = 6,
  parameter int AW    = 16
) (
  input  logic [AW-1:0]    addr_i,
  output logic [IDW-1:0]   id_o,
  output logic             alias_o,
  output logic [OFS_W-1:0] ofs_o,
  output logic [NP-1:0]    hit_o,
  output logic             valid_o
);
  assign id_o    = addr_i[OFS_W +: IDW];
  assign alias_o = addr_i[AW-1];
  assign ofs_o   = addr_i[OFS_W-1:0];

  for (genvar n = 0; n < NP; n++) begin : g_slot
    assign hit_o[n] = (id_o == IDW'(n));
  end

  assign valid_o = |hit_o;
endmodule

// File: rtl/pg_check.sv
module pg_check #(
  parameter int          IDW     = 6,
  parameter logic [63:0] SEC_MAP = 64'h0
) (
  input  logic           req_i,
  input  logic           valid_i,
  input  logic           priv_i,
  input  logic           sec_i,
  input  logic           alias_i,
  input  logic [IDW-1:0] id_i,
  input  logic           en_i,
  input  logic [63:0]    prot_i,
  output logic           priv_flt_o,
  output logic           sec_flt_o,
  output logic           block_o
);
  logic act, need_priv, is_secure;

  assign act        = req_i & valid_i & en_i;
  assign need_priv  = prot_i[id_i];
  assign is_secure  = SEC_MAP[id_i];
  assign priv_flt_o = act & need_priv & ~priv_i;
  // wrong alias for the peripheral, or secure alias from a non-secure master
  assign sec_flt_o  = act & ((alias_i != is_secure) | (alias_i & ~sec_i));
  assign block_o    = priv_flt_o | sec_flt_o;
endmodule

// File: rtl/pg_regs.sv
module pg_regs
  import periph_guard_pkg::*;
#(
  parameter int IDW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              c_req_i,
  input  logic              c_we_i,
  input  logic [2:0]        c_addr_i,
  input  logic [CFG_W-1:0]  c_wdata_i,
  input  logic              c_priv_i,
  output logic [CFG_W-1:0]  c_rdata_o,
  input  logic [FLAG_W-1:0] hw_flt_i,
  input  logic [IDW-1:0]    flt_id_i,
  output logic              en_o,
  output logic [63:0]       prot_o,
  output logic              irq_o
);
  logic              en_q;
  logic [63:0]       prot_q;
  logic [FLAG_W-1:0] flags_q, ien_q, set_v, clr_v, kept;
  logic [IDW-1:0]    fid_q;
  logic              wr, wr_priv;
  logic              ctrl_wr, lo_wr, hi_wr, set_wr, clr_wr, ien_wr;

  assign wr      = c_req_i & c_we_i;
  assign wr_priv = wr & c_priv_i;
  assign ctrl_wr = wr_priv & (c_addr_i == REG_CTRL);
  assign lo_wr   = wr_priv & (c_addr_i == REG_PROT_LO);
  assign hi_wr   = wr_priv & (c_addr_i == REG_PROT_HI);
  assign set_wr  = wr & (c_addr_i == REG_SET);
  assign clr_wr  = wr & (c_addr_i == REG_CLR);
  assign ien_wr  = wr & (c_addr_i == REG_IEN);

  assign set_v = (set_wr ? c_wdata_i[FLAG_W-1:0] : '0) | hw_flt_i;
  assign clr_v =  clr_wr ? c_wdata_i[FLAG_W-1:0] : '0;
  assign kept  = flags_q & ~clr_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b1;
      prot_q  <= '0;
      flags_q <= '0;
      ien_q   <= '0;
      fid_q   <= '0;
    end else begin
      if (ctrl_wr) en_q <= c_wdata_i[0];
      if (lo_wr)   prot_q[31:0]  <= c_wdata_i;
      if (hi_wr)   prot_q[63:32] <= c_wdata_i;
      if (ien_wr)  ien_q <= c_wdata_i[FLAG_W-1:0];
      flags_q <= kept | set_v;
      // first fault wins until every pending flag is cleared
      if ((|hw_flt_i) && (kept == '0)) fid_q <= flt_id_i;
    end
  end

  always_comb begin
    case (c_addr_i)
      REG_CTRL:    c_rdata_o = {{(CFG_W-1){1'b0}}, en_q};
      REG_PROT_LO: c_rdata_o = prot_q[31:0];
      REG_PROT_HI: c_rdata_o = prot_q[63:32];
      REG_FLAGS:   c_rdata_o = {{(CFG_W-FLAG_W){1'b0}}, flags_q};
      REG_IEN:     c_rdata_o = {{(CFG_W-FLAG_W){1'b0}}, ien_q};
      REG_FID:     c_rdata_o = {{(CFG_W-IDW){1'b0}}, fid_q};
      default:     c_rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign prot_o = prot_q;
  assign irq_o  = |(flags_q & ien_q);

  a_r4_priv_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_flt_i[FLG_PRIV] |=> flags_q[FLG_PRIV]);
  a_r5_sec_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_flt_i[FLG_SEC] |=> flags_q[FLG_SEC]);
  a_r6_id_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|flags_q) && !clr_wr) |=> $stable(fid_q));
  a_r7_irq_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_flt_i[FLG_PRIV] && ien_q[FLG_PRIV] && !ien_wr) |=> irq_o);
  a_r10_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_req_i && c_we_i && !c_priv_i) |=> ($stable(prot_q) && $stable(en_q)));
endmodule

// File: rtl/periph_guard.sv
module periph_guard
  import periph_guard_pkg::*;
#(
  parameter int          NP      = 64,
  parameter int          OFS_W   = 9,
  parameter int          DW      = 32,
  parameter logic [63:0] SEC_MAP = 64'h0000_0000_0000_000C,
  localparam int         IDW     = $clog2(NP),
  localparam int         AW      = OFS_W + IDW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             m_req_i,
  input  logic             m_we_i,
  input  logic [AW-1:0]    m_addr_i,
  input  logic [DW-1:0]    m_wdata_i,
  input  logic             m_priv_i,
  input  logic             m_sec_i,
  output logic [DW-1:0]    m_rdata_o,
  output logic [NP-1:0]    p_sel_o,
  output logic             p_we_o,
  output logic [OFS_W-1:0] p_addr_o,
  output logic [DW-1:0]    p_wdata_o,
  input  logic [DW-1:0]    p_rdata_i,
  input  logic             c_req_i,
  input  logic             c_we_i,
  input  logic [2:0]       c_addr_i,
  input  logic [CFG_W-1:0] c_wdata_i,
  input  logic             c_priv_i,
  output logic [CFG_W-1:0] c_rdata_o,
  output logic             irq_o
);
  logic [IDW-1:0] id;
  logic           alias_sec, valid, en, priv_flt, sec_flt, block, pass;
  logic [NP-1:0]  hit;
  logic [63:0]    prot;

  pg_decode #(.NP(NP), .OFS_W(OFS_W), .IDW(IDW), .AW(AW)) i_decode (
    .addr_i(m_addr_i), .id_o(id), .alias_o(alias_sec), .ofs_o(p_addr_o),
    .hit_o(hit), .valid_o(valid)
  );

  pg_check #(.IDW(IDW), .SEC_MAP(SEC_MAP)) i_check (
    .req_i(m_req_i), .valid_i(valid), .priv_i(m_priv_i), .sec_i(m_sec_i),
    .alias_i(alias_sec), .id_i(id), .en_i(en), .prot_i(prot),
    .priv_flt_o(priv_flt), .sec_flt_o(sec_flt), .block_o(block)
  );

  pg_regs #(.IDW(IDW)) i_regs (
    .clk_i, .rst_ni, .c_req_i, .c_we_i, .c_addr_i, .c_wdata_i, .c_priv_i,
    .c_rdata_o, .hw_flt_i({sec_flt, priv_flt}), .flt_id_i(id),
    .en_o(en), .prot_o(prot), .irq_o
  );

  assign pass      = m_req_i & valid & ~block;
  assign p_sel_o   = pass ? hit : '0;
  assign p_we_o    = pass & m_we_i;
  assign p_wdata_o = m_wdata_i;
  assign m_rdata_o = (pass & ~m_we_i) ? p_rdata_i : '0;

  a_r1_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(p_sel_o));
  a_r2_block_unpriv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_i && en && valid && prot[id] && !m_priv_i) |-> (p_sel_o == '0 && !p_we_o));
  a_r3_zero_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_i && !m_we_i && p_sel_o == '0) |-> (m_rdata_o == '0));
endmodule

// File: tb/test_periph_guard.sv
module test_periph_guard;
  localparam logic [31:0] PDATA = 32'hCAFE_1234;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        m_req = 0, m_we = 0, m_priv = 0, m_sec = 0;
  logic [15:0] m_addr = '0;
  logic [31:0] m_wdata = '0, m_rdata;
  logic [63:0] p_sel;
  logic        p_we;
  logic [8:0]  p_addr;
  logic [31:0] p_wdata;
  logic        c_req = 0, c_we = 0, c_priv = 0;
  logic [2:0]  c_addr = '0;
  logic [31:0] c_wdata = '0, c_rdata;
  logic        irq;

  int checks = 0, errors = 0;
  logic [63:0] s_sel;
  logic        s_we;
  logic [31:0] s_rdata;
  logic [8:0]  s_addr;

  always #2.5 clk = ~clk;

  periph_guard i_periph_guard (
    .clk_i(clk), .rst_ni(rst_n), .m_req_i(m_req), .m_we_i(m_we), .m_addr_i(m_addr),
    .m_wdata_i(m_wdata), .m_priv_i(m_priv), .m_sec_i(m_sec), .m_rdata_o(m_rdata),
    .p_sel_o(p_sel), .p_we_o(p_we), .p_addr_o(p_addr), .p_wdata_o(p_wdata),
    .p_rdata_i(PDATA), .c_req_i(c_req), .c_we_i(c_we), .c_addr_i(c_addr),
    .c_wdata_i(c_wdata), .c_priv_i(c_priv), .c_rdata_o(c_rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic sa, input int id, input int ofs);
    return {sa, 6'(id), 9'(ofs)};
  endfunction

  task automatic setbus(input logic sa, input int id, input int ofs, input logic we,
                        input logic pv, input logic sc);
    m_req = 1; m_we = we; m_addr = mk(sa, id, ofs); m_priv = pv; m_sec = sc;
    m_wdata = 32'h5555_AAAA;
  endtask

  task automatic access(input logic sa, input int id, input int ofs, input logic we,
                        input logic pv, input logic sc);
    @(negedge clk);
    setbus(sa, id, ofs, we, pv, sc);
    #1;
    s_sel = p_sel; s_we = p_we; s_rdata = m_rdata; s_addr = p_addr;
    @(posedge clk); #1;
    m_req = 0; m_we = 0;
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d, input logic pv);
    @(negedge clk);
    c_req = 1; c_we = 1; c_addr = a; c_wdata = d; c_priv = pv;
    @(posedge clk); #1;
    c_req = 0; c_we = 0;
  endtask

  task automatic cfg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    c_req = 1; c_we = 0; c_addr = a;
    #1 d = c_rdata;
    c_req = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    cfg_rd(3'd0, d); chk("R9 reset enable", d, 1);
    cfg_rd(3'd1, d); chk("R9 reset prot lo", d, 0);
    cfg_rd(3'd2, d); chk("R9 reset prot hi", d, 0);
    cfg_rd(3'd3, d); chk("R9 reset flags", d, 0);
    cfg_rd(3'd7, d); chk("R9 reset fid", d, 0);
    chk("R9 reset irq", irq, 0);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    access(0, 7, 'h1A4, 0, 0, 0);
    chk("R1 sel id7", s_sel, 64'd1 << 7);
    chk("R1 offset", s_addr, 9'h1A4);
    chk("R3 read passes", s_rdata, PDATA);
    access(0, 50, 'h10, 1, 0, 0);
    chk("R1 sel id50", s_sel, 64'd1 << 50);
    chk("R1 write strobe", s_we, 1);
    access(1, 3, 0, 0, 0, 1);
    chk("R5 secure alias ok", s_sel, 64'd1 << 3);
    cfg_rd(3'd3, d); chk("R4 no flags on legal", d, 0);
  endtask

  task automatic t_priv;
    logic [31:0] d;
    cfg_wr(3'd1, 32'd1 << 5, 1);
    access(0, 5, 4, 0, 0, 0);
    chk("R2 blocked sel", s_sel, 0);
    chk("R3 blocked read zero", s_rdata, 0);
    cfg_rd(3'd3, d); chk("R4 priv flag", d, 1);
    cfg_rd(3'd7, d); chk("R4 fid", d, 5);
    access(0, 5, 4, 0, 1, 0);
    chk("R2 privileged passes", s_sel, 64'd1 << 5);
    cfg_wr(3'd5, 3, 0);
    cfg_rd(3'd3, d); chk("R8 w1c", d, 0);
    cfg_wr(3'd2, 32'd1 << 8, 1);
    access(0, 40, 8, 1, 0, 0);
    chk("R2 hi word blocks we", s_we, 0);
    chk("R2 hi word blocks sel", s_sel, 0);
    cfg_rd(3'd7, d); chk("R4 fid 40", d, 40);
    cfg_wr(3'd5, 3, 0);
  endtask

  task automatic t_sec;
    logic [31:0] d;
    access(0, 2, 0, 0, 1, 1);
    chk("R5 secure via ns alias blocked", s_sel, 0);
    cfg_rd(3'd3, d); chk("R5 sec flag", d, 2);
    cfg_rd(3'd7, d); chk("R5 fid 2", d, 2);
    cfg_wr(3'd5, 3, 0);
    access(1, 41, 0, 0, 1, 1);
    chk("R5 ns via secure alias blocked", s_sel, 0);
    cfg_rd(3'd7, d); chk("R5 fid 41", d, 41);
    cfg_wr(3'd5, 3, 0);
    access(1, 3, 0, 0, 1, 0);
    chk("R5 nonsecure master on secure alias", s_sel, 0);
    cfg_rd(3'd3, d); chk("R5 sec flag again", d, 2);
    cfg_wr(3'd5, 3, 0);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    access(0, 5, 0, 0, 0, 0);
    access(0, 40, 0, 0, 0, 0);
    cfg_rd(3'd7, d); chk("R6 first id held", d, 5);
    @(negedge clk);
    setbus(0, 2, 0, 0, 1, 1);
    c_req = 1; c_we = 1; c_addr = 3'd5; c_wdata = 3; c_priv = 0;
    @(posedge clk); #1;
    m_req = 0; c_req = 0; c_we = 0;
    cfg_rd(3'd3, d); chk("R6 hw set beats clear", d, 2);
    cfg_rd(3'd7, d); chk("R6 new id on clear", d, 2);
    cfg_wr(3'd5, 3, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    cfg_wr(3'd4, 1, 0);
    cfg_rd(3'd3, d); chk("R8 w1s", d, 1);
    chk("R7 no irq while disabled", irq, 0);
    cfg_wr(3'd6, 1, 0);
    #1 chk("R7 pending then enable", irq, 1);
    cfg_wr(3'd5, 1, 0);
    #1 chk("R7 irq drops on clear", irq, 0);
    cfg_wr(3'd6, 2, 0);
    access(0, 3, 0, 0, 1, 1);
    #1 chk("R7 sec irq", irq, 1);
    cfg_wr(3'd5, 3, 0);
    cfg_wr(3'd6, 0, 0);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    cfg_wr(3'd1, 32'hFFFF_FFFF, 0);
    cfg_rd(3'd1, d); chk("R10 prot lo locked", d, 32'd1 << 5);
    cfg_wr(3'd0, 0, 0);
    cfg_rd(3'd0, d); chk("R10 ctrl locked", d, 1);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    cfg_wr(3'd0, 0, 1);
    access(0, 5, 0, 0, 0, 0);
    chk("R9 disabled passes", s_rdata, PDATA);
    access(0, 2, 0, 0, 0, 0);
    chk("R9 disabled sec passes", s_sel, 64'd1 << 2);
    cfg_rd(3'd3, d); chk("R9 no flags when off", d, 0);
    cfg_wr(3'd0, 1, 1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12 rst_n = 1;
    t_reset;
    t_decode;
    t_priv;
    t_sec;
    t_sticky;
    t_irq;
    t_lock;
    t_disable;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule